// File: doc/BRIEF.md
# Zero-Suppressed Channel Readout Sequencer

This block drives the serial conversion of a 32-channel front-end chip. When a start pulse is accepted it captures a per-channel hit bitmap, with bit i belonging to channel i, and walks the channels from 0 upward. A channel whose bit is set gets a full conversion step, with strobes for the analog front end and the ADC. A channel whose bit is clear is stepped past in one cycle, or two when the design is built that way. The walk stops as soon as the highest set channel has been converted, so channels above it cost nothing.

Each converted channel produces one hit record: its 5-bit channel index and the ADC sample captured during the step. The sequencer never asks the upstream sample pipeline to pause. As a result, no flush or reset interval separates two events, and a new start can be taken in the first idle cycle after done.

Top module: `zs_scan_seq`

## Requirements
- R1: Hit records appear only for channels whose bitmap bit is set (bit i is channel i), one record per such channel, in ascending channel order, with `rec_ch_o` carrying the index.
- R2: A set channel takes exactly 6 cycles. `hold_o` is high in cycle 1, `conv_o` in cycles 2 to 4, `rd_o` in cycle 5 and `rec_valid_o` in cycle 6. At most one of these four is high in any cycle.
- R3: The value on `adc_data_i` during the `rd_o` cycle of a channel appears on `rec_smp_o` while `rec_valid_o` is high in the next cycle.
- R4: A clear channel below the last hit takes SKIP_CYC cycles (default 1, value 2 allowed) and produces no strobe.
- R5: The scan ends after the highest set channel L. With H set channels, busy-before-done lasts 6·H + SKIP_CYC·(L+1−H) cycles. `ch_adv_o` pulses exactly L times, and each pulse raises `ch_idx_o` by one in the next cycle.
- R6: An all-zero bitmap raises `done_o` in the cycle after the start is accepted, with no record and no strobe.
- R7: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `done_o` is a one-cycle pulse and is followed by an idle cycle.
- R8: `start_i` is ignored while `busy_o` is high, including the done cycle. The bitmap is sampled only at an accepted start, so later changes to `hit_map_i` have no effect.
- R9: A start in the first idle cycle after done is accepted and runs a complete scan, with no flush interval between events.
- R10: While `rst_ni` is low, `busy_o`, `done_o`, `rec_valid_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| hit_map_i | input | 32 | Discriminator hit bitmap, bit i = channel i |
| adc_data_i | input | 12 | ADC conversion result |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| ch_idx_o | output | 5 | Channel currently visited |
| ch_adv_o | output | 1 | Advance the front end to the next channel |
| hold_o | output | 1 | Select and hold strobe, step cycle 1 |
| conv_o | output | 1 | Conversion strobe, step cycles 2 to 4 |
| rd_o | output | 1 | ADC read strobe, step cycle 5 |
| rec_valid_o | output | 1 | Hit record valid |
| rec_ch_o | output | 5 | Hit record channel index |
| rec_smp_o | output | 12 | Hit record sample |

## Verification
The bench targets the bitmap extremes: empty, only channel 0, only channel 31, all channels set, and hits separated by long clear stretches. A design that scanned all 32 channels would miss the cycle totals on sparse maps. One that mistimed the latch would report the stub's out-of-window value instead of the channel sample. One that mishandled the empty map would stall or emit a record. A second instance with two-cycle skips shows whether the skip cost follows the parameter. Start pulses during a scan and during the done cycle, together with a bitmap changed mid-scan, show whether a sequencer re-arms or picks up a stale bitmap. Back-to-back starts show whether a restart wrongly needs a gap.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } zs_state_e;
endpackage

// File: rtl/zs_last_hit.sv
module zs_last_hit #(
  parameter int N_CH = 32,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] map_i,
  output logic            any_o,
  output logic [CH_W-1:0] last_o
);
  always_comb begin
    last_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (map_i[i]) last_o = CH_W'(i);
    end
  end

  assign any_o = |map_i;
endmodule

// File: rtl/zs_step_ctr.sv
module zs_step_ctr #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/zs_strobe_dec.sv
module zs_strobe_dec #(
  parameter int HIT_CYC  = 6,
  parameter int SKIP_CYC = 1,
  localparam int STEP_W  = $clog2(HIT_CYC)
) (
  input  logic              active_i,
  input  logic              hit_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              last_cyc_o,
  output logic              hold_o,
  output logic              conv_o,
  output logic              rd_o,
  output logic              rec_o
);
  localparam logic [STEP_W-1:0] HIT_END  = STEP_W'(HIT_CYC - 1);
  localparam logic [STEP_W-1:0] SKIP_END = STEP_W'(SKIP_CYC - 1);
  localparam logic [STEP_W-1:0] RD_STEP  = STEP_W'(HIT_CYC - 2);
  localparam logic [STEP_W-1:0] CONV_END = STEP_W'(HIT_CYC - 3);

  logic on_hit;
  assign on_hit = active_i & hit_i;

  assign last_cyc_o = active_i & (step_i == (hit_i ? HIT_END : SKIP_END));
  assign hold_o     = on_hit & (step_i == '0);
  assign conv_o     = on_hit & (step_i != '0) & (step_i <= CONV_END);
  assign rd_o       = on_hit & (step_i == RD_STEP);
  assign rec_o      = on_hit & (step_i == HIT_END);
endmodule

// File: rtl/zs_scan_seq.sv
module zs_scan_seq #(
  parameter int N_CH     = 32,
  parameter int SMP_W    = 12,
  parameter int HIT_CYC  = 6,
  parameter int SKIP_CYC = 1,
  localparam int CH_W    = $clog2(N_CH),
  localparam int STEP_W  = $clog2(HIT_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [N_CH-1:0]  hit_map_i,
  input  logic [SMP_W-1:0] adc_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CH_W-1:0]  ch_idx_o,
  output logic             ch_adv_o,
  output logic             hold_o,
  output logic             conv_o,
  output logic             rd_o,
  output logic             rec_valid_o,
  output logic [CH_W-1:0]  rec_ch_o,
  output logic [SMP_W-1:0] rec_smp_o
);
  import zs_pkg::*;

  zs_state_e         state_q;
  logic [N_CH-1:0]   map_q;
  logic [CH_W-1:0]   last_q, ch_q, last_d;
  logic [SMP_W-1:0]  smp_q;
  logic [STEP_W-1:0] step;
  logic              any_d, active, cur_hit, last_cyc, at_last, rd_s;

  zs_last_hit #(.N_CH(N_CH)) u_last (
    .map_i (hit_map_i),
    .any_o (any_d),
    .last_o(last_d)
  );

  assign active  = (state_q == ST_SCAN);
  assign cur_hit = map_q[ch_q];
  assign at_last = (ch_q == last_q);

  zs_step_ctr #(.W(STEP_W)) u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~active | last_cyc),
    .en_i  (active),
    .cnt_o (step)
  );

  zs_strobe_dec #(.HIT_CYC(HIT_CYC), .SKIP_CYC(SKIP_CYC)) u_dec (
    .active_i  (active),
    .hit_i     (cur_hit),
    .step_i    (step),
    .last_cyc_o(last_cyc),
    .hold_o    (hold_o),
    .conv_o    (conv_o),
    .rd_o      (rd_s),
    .rec_o     (rec_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      map_q   <= '0;
      last_q  <= '0;
      ch_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          map_q   <= hit_map_i;
          last_q  <= last_d;
          ch_q    <= '0;
          state_q <= any_d ? ST_SCAN : ST_FIN;
        end
        ST_SCAN: if (last_cyc) begin
          if (at_last) state_q <= ST_FIN;
          else         ch_q    <= ch_q + 1'b1;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // sample captured at the end of the read cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   smp_q <= '0;
    else if (rd_s) smp_q <= adc_data_i;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);
  assign ch_idx_o  = ch_q;
  assign ch_adv_o  = last_cyc & ~at_last;
  assign rd_o      = rd_s;
  assign rec_ch_o  = ch_q;
  assign rec_smp_o = smp_q;
endmodule

// File: rtl/zs_scan_seq_chk.sv
module zs_scan_seq_chk #(
  parameter int N_CH  = 32,
  parameter int SMP_W = 12,
  localparam int CH_W = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [N_CH-1:0] hit_map_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [CH_W-1:0] ch_idx_o,
  input logic            ch_adv_o,
  input logic            hold_o,
  input logic            conv_o,
  input logic            rd_o,
  input logic            rec_valid_o
);
  // R7
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R3
  rec_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> $past(rd_o));
  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hold_o, conv_o, rd_o, rec_valid_o}));
  // R5
  adv_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_adv_o |=> (ch_idx_o == $past(ch_idx_o) + 1'b1));
  // R6
  empty_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && hit_map_i == '0) |=> done_o);
  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

bind zs_scan_seq zs_scan_seq_chk #(.N_CH(N_CH), .SMP_W(SMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .hit_map_i  (hit_map_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .ch_idx_o   (ch_idx_o),
  .ch_adv_o   (ch_adv_o),
  .hold_o     (hold_o),
  .conv_o     (conv_o),
  .rd_o       (rd_o),
  .rec_valid_o(rec_valid_o)
);

// File: tb/zs_scan_seq_bench.sv
module zs_scan_seq_bench;
  localparam int NV = 9;
  localparam logic [31:0] MAPS [NV] = '{
    32'h0000_0000, 32'h0000_0001, 32'h8000_0000, 32'h0000_0005, 32'hFFFF_FFFF,
    32'h0001_0100, 32'h8000_0001, 32'h0000_F000, 32'h4000_0002};
  // expected busy-before-done cycles with one-cycle skips
  localparam int EXP_CYC [NV] = '{0, 6, 37, 13, 192, 27, 42, 36, 41};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] map_in = '0;
  int salt = 0;
  int checks = 0, fails = 0;

  logic [11:0] adc_a, adc_b, smp_a, smp_b;
  logic [4:0] ch_a, ch_b, rch_a, rch_b;
  logic busy_a, done_a, adv_a, hold_a, conv_a, rd_a, rec_a;
  logic busy_b, done_b, adv_b, hold_b, conv_b, rd_b, rec_b;

  always #5 clk = ~clk;

  function automatic logic [11:0] smp_of(input logic [4:0] c, input int s);
    return 12'((int'(c) * 73 + s) & 32'h7FF);
  endfunction

  // ADC stub: valid data only in the read cycle
  assign adc_a = rd_a ? smp_of(ch_a, salt) : 12'hFFF;
  assign adc_b = rd_b ? smp_of(ch_b, salt) : 12'hFFF;

  zs_scan_seq u_zs_scan_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hit_map_i(map_in), .adc_data_i(adc_a),
    .busy_o(busy_a), .done_o(done_a), .ch_idx_o(ch_a), .ch_adv_o(adv_a), .hold_o(hold_a),
    .conv_o(conv_a), .rd_o(rd_a), .rec_valid_o(rec_a), .rec_ch_o(rch_a), .rec_smp_o(smp_a));

  zs_scan_seq #(.SKIP_CYC(2)) u_zs_scan_seq_s2 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hit_map_i(map_in), .adc_data_i(adc_b),
    .busy_o(busy_b), .done_o(done_b), .ch_idx_o(ch_b), .ch_adv_o(adv_b), .hold_o(hold_b),
    .conv_o(conv_b), .rd_o(rd_b), .rec_valid_o(rec_b), .rec_ch_o(rch_b), .rec_smp_o(smp_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int top_bit(input logic [31:0] m);
    int r = 0;
    for (int i = 0; i < 32; i++) if (m[i]) r = i;
    return r;
  endfunction

  function automatic int scan_len(input logic [31:0] m, input int skip);
    int h = $countones(m);
    if (h == 0) return 0;
    return 6 * h + skip * (top_bit(m) + 1 - h);
  endfunction

  // Called at a negedge with both instances idle.
  task automatic run_scan(input logic [31:0] m, input int exp_a, input bit poke);
    int cyc_a = 0, cyc_b = 0, recs = 0, advs = 0, holds = 0, convs = 0, rds = 0;
    int ptr = 0, n = 0, h, l;
    bit da = 0, db = 0, pd = 0;
    h = $countones(m);
    l = (h == 0) ? 0 : top_bit(m);
    salt = salt + 97;
    start = 1'b1;
    map_in = m;
    @(negedge clk);
    start = 1'b0;
    if (poke) map_in = ~m;
    while (!(da && db) && n < 2000) begin
      start = 1'b0;
      if (!da) begin
        if (done_a) begin
          da = 1;
          if (poke) begin start = 1'b1; pd = 1; end
        end else begin
          cyc_a++;
          if (adv_a) advs++;
          if (hold_a) holds++;
          if (conv_a) convs++;
          if (rd_a) rds++;
          if (rec_a) begin
            int j = ptr;
            while (j < 32 && !m[j]) j++;
            // R1 ascending channel order, only set bits
            chk(j < 32 && rch_a == 5'(j), "R1 record channel", int'(rch_a), j);
            // R3 sample from the read cycle
            chk(j < 32 && smp_a == smp_of(5'(j), salt), "R3 record sample", int'(smp_a),
                int'(smp_of(5'(j), salt)));
            ptr = j + 1;
            recs++;
          end
        end
      end
      if (!db) begin
        if (done_b) db = 1;
        else cyc_b++;
      end
      if (poke && n == 3) start = 1'b1;
      n++;
      if (!(da && db)) @(negedge clk);
    end
    chk(n < 2000, "R7 scan completes", n, 2000);
    chk(cyc_a == exp_a, "R5 scan length", cyc_a, exp_a);
    chk(cyc_b == scan_len(m, 2), "R4 two-cycle skip length", cyc_b, scan_len(m, 2));
    chk(recs == h, "R1 record count", recs, h);
    chk(advs == l, "R5 channel advances", advs, l);
    chk(holds == h && rds == h, "R2 hold/read strobe count", holds + rds, 2 * h);
    chk(convs == 3 * h, "R2 conversion strobe count", convs, 3 * h);
    if (h == 0) chk(cyc_a == 0 && recs == 0, "R6 empty map", cyc_a, 0);
    @(negedge clk);
    start = 1'b0;
    // R8 start during scan or done cycle did not re-arm
    chk(!busy_a && !busy_b, "R8 idle after done", int'(busy_a) + int'(busy_b), 0);
    if (pd) chk(!done_a, "R8 no extra done", int'(done_a), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_a && !done_a && !rec_a && !hold_a && !conv_a && !rd_a, "R10 reset outputs",
        int'(busy_a) + int'(done_a) + int'(rec_a), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk; consecutive entries also restart in the first idle cycle (R9)
    for (int v = 0; v < NV; v++) run_scan(MAPS[v], EXP_CYC[v], 1'b0);

    // R8 start pulses mid-scan and in the done cycle, bitmap changed after start
    run_scan(32'h0010_0204, scan_len(32'h0010_0204, 1), 1'b1);
    run_scan(32'h0000_0000, 0, 1'b1);

    // R9 immediate restart after a full-map scan (both instances finish together)
    run_scan(32'hFFFF_FFFF, 192, 1'b0);
    run_scan(32'h0000_0001, 6, 1'b0);

    // R10 asynchronous reset in the middle of a scan
    start = 1'b1;
    map_in = 32'h0000_0300;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy_a && !busy_b && !hold_a && !conv_a && !rd_a, "R10 reset mid-scan",
        int'(busy_a) + int'(busy_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_scan(32'h0000_0300, scan_len(32'h0000_0300, 1), 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule